// File: doc/BRIEF.md
# Transition-Mode PFC Switching Sequencer

This block is the cycle controller for a boost or flyback power-factor stage that runs in critical conduction. All of its inputs are comparator flags that arrive asynchronously and have already been digitised. Two of them come from an auxiliary winding on the inductor: an "arm" flag that is high while the winding voltage is above the upper threshold, and a "trigger" flag that is high while it is below the lower threshold. The others are an over-current flag, a static bus over-voltage flag, a dynamic (transient) over-voltage flag and a supply-undervoltage flag. The block also takes an on-time request, counted in clock cycles. From these it drives one gate-enable output.

Each switching cycle runs as a fixed sequence:
1. The gate turns on and is held for the clamped on-time.
2. The gate turns off.
3. The block waits for the winding to show demagnetisation. The arm flag must rise first and the trigger flag must rise after it.
4. The gate turns on again.

If that sequence does not arrive, a watchdog forces periodic turn-ons. Over-current trips are ignored during a blanking window at the start of each pulse. Any of the three suppression flags holds the gate off. A status output reports whether the latest turn-on came from the watchdog.

Top module: `pfc_seq_top`

## Requirements
- R1: The gate turns on only after a filtered rising edge of `zx_trig_i` that follows a filtered rising edge of `zx_arm_i` seen since the previous turn-on. The pulse then lasts exactly the clamped on-time in clock cycles.
- R2: A rising edge of `zx_trig_i` with no arm edge before it since the previous turn-on does not turn the gate on.
- R3: While the gate is off and not suppressed, a turn-on is forced `WD_CYCLES` cycles after the previous turn-on. Forced pulses repeat at that interval and each lasts the clamped on-time. `wd_start_o` is 1 after a forced turn-on.
- R4: A turn-on from a valid arm-then-trigger sequence sets `wd_start_o` to 0, so normal cycling resumes after forced pulses.
- R5: The on-time request is latched at turn-on and clamped to the range [`TON_MIN`, `TON_MAX`] cycles.
- R6: Over-current is ignored for the first `BLANK_CYCLES` cycles of a pulse. If the over-current flag is held high from turn-on, the pulse lasts `BLANK_CYCLES+1` cycles. After a trip, the next turn-on again needs a trigger or the watchdog.
- R7: While `ovp_static_i` is high, the gate is held off and no turn-on (triggered or forced) takes place. A pulse in progress ends within 3 cycles.
- R8: While `ovp_dyn_i` is high, the gate is held off. A pulse in progress ends within 3 cycles, and cycling resumes once the flag clears.
- R9: After reset, and while `uvlo_i` is high, `gate_o` is 0. After reset, `wd_start_o` is 0.
- R10: A level change on either zero-crossing flag is ignored unless it lasts `FILT_CYCLES` consecutive synchronised cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| zx_arm_i | input | 1 | Winding voltage above the arm threshold (async) |
| zx_trig_i | input | 1 | Winding voltage below the trigger threshold (async) |
| oc_i | input | 1 | Switch current above the limit (async) |
| ovp_static_i | input | 1 | Bus feedback above the static over-voltage level (async) |
| ovp_dyn_i | input | 1 | Large sink current from the error amplifier (async) |
| uvlo_i | input | 1 | Supply in undervoltage lockout (async) |
| ton_req_i | input | TON_W | Requested on-time, in clock cycles |
| gate_o | output | 1 | Gate-drive enable |
| wd_start_o | output | 1 | The latest turn-on was forced by the watchdog |

## Verification
The following are checked as properties on every cycle:
- the suppression flags force the gate off on the next cycle;
- a held undervoltage keeps the gate low;
- the latched on-time stays inside its clamp range;
- the watchdog and filter counters stay in range;
- a turn-on marked as non-forced was armed beforehand.

Only the bench scenarios can show the exact pulse widths, the watchdog period, glitch rejection on the zero-crossing flags, and the blanking-limited width of an over-current pulse. They also show that suppression defeats both triggered and forced turn-ons, and that triggered cycling returns after watchdog operation.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;
  typedef enum logic {ST_OFF = 1'b0, ST_ON = 1'b1} pfc_state_e;

  localparam int NUM_FLAGS = 6;
  localparam int IDX_ARM   = 0;
  localparam int IDX_TRIG  = 1;
  localparam int IDX_OC    = 2;
  localparam int IDX_OVS   = 3;
  localparam int IDX_OVD   = 4;
  localparam int IDX_UV    = 5;
endpackage

// File: rtl/pfc_sync2.sv
module pfc_sync2 #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pfc_stable_filt.sv
module pfc_stable_filt #(
  parameter int N           = 2,
  parameter int FILT_CYCLES = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  localparam int CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES + 1);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [CW-1:0] cnt_q;
    logic          f_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        f_q   <= 1'b0;
      end else if (d_i[i] == f_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
        f_q   <= d_i[i];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    assign q_o[i] = f_q;

    p_filt_cnt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < CW'(FILT_CYCLES))
      else $error("filter counter out of range");
  end
endmodule

// File: rtl/pfc_watchdog.sv
module pfc_watchdog #(
  parameter int WD_CYCLES = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic expire_o
);
  localparam int WW = $clog2(WD_CYCLES);
  localparam logic [WW-1:0] LAST = WW'(WD_CYCLES - 1);

  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clear_i)         cnt_q <= '0;
    else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = (cnt_q == LAST);

  p_wd_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST)
    else $error("watchdog counter out of range");
endmodule

// File: rtl/pfc_on_timer.sv
module pfc_on_timer #(
  parameter int TON_W        = 16,
  parameter int TON_MIN      = 38,
  parameter int TON_MAX      = 6250,
  parameter int BLANK_CYCLES = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             oc_i,
  input  logic [TON_W-1:0] ton_req_i,
  output logic             done_o
);
  localparam int TOP  = (TON_MAX > BLANK_CYCLES) ? TON_MAX : BLANK_CYCLES;
  localparam int CNT_W = $clog2(TOP + 1);

  logic [CNT_W-1:0] ton_clamp, ton_lat_q, on_cnt_q;
  logic             at_end, oc_trip;

  always_comb begin
    if (int'(ton_req_i) < TON_MIN)      ton_clamp = CNT_W'(TON_MIN);
    else if (int'(ton_req_i) > TON_MAX) ton_clamp = CNT_W'(TON_MAX);
    else                                ton_clamp = CNT_W'(ton_req_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ton_lat_q <= CNT_W'(TON_MIN);
      on_cnt_q  <= '0;
    end else if (start_i) begin
      ton_lat_q <= ton_clamp;
      on_cnt_q  <= '0;
    end else if (run_i) begin
      on_cnt_q  <= on_cnt_q + 1'b1;
    end
  end

  assign at_end  = (on_cnt_q == ton_lat_q - 1'b1);
  assign oc_trip = oc_i && (on_cnt_q >= CNT_W'(BLANK_CYCLES));
  assign done_o  = run_i && (at_end || oc_trip);

  p_ton_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (ton_lat_q >= CNT_W'(TON_MIN)) && (ton_lat_q <= CNT_W'(TON_MAX)))
    else $error("latched on-time outside clamp");

  p_on_cnt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> on_cnt_q < ton_lat_q)
    else $error("on-period overran latched on-time");
endmodule

// File: rtl/pfc_seq_top.sv
module pfc_seq_top
  import pfc_seq_pkg::*;
#(
  parameter int TON_W        = 16,
  parameter int TON_MIN      = 38,
  parameter int TON_MAX      = 6250,
  parameter int BLANK_CYCLES = 40,
  parameter int WD_CYCLES    = 50000,
  parameter int FILT_CYCLES  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zx_arm_i,
  input  logic             zx_trig_i,
  input  logic             oc_i,
  input  logic             ovp_static_i,
  input  logic             ovp_dyn_i,
  input  logic             uvlo_i,
  input  logic [TON_W-1:0] ton_req_i,
  output logic             gate_o,
  output logic             wd_start_o
);
  logic [NUM_FLAGS-1:0] raw, syn;
  logic [1:0]           zx_f;
  pfc_state_e           state_q;
  logic                 armed_q, arm_fq, trig_fq, wd_start_q;
  logic                 suppress, arm_rise, trig_evt, wd_expire, turn_on, tmr_done, gate_on;

  assign raw[IDX_ARM]  = zx_arm_i;
  assign raw[IDX_TRIG] = zx_trig_i;
  assign raw[IDX_OC]   = oc_i;
  assign raw[IDX_OVS]  = ovp_static_i;
  assign raw[IDX_OVD]  = ovp_dyn_i;
  assign raw[IDX_UV]   = uvlo_i;

  pfc_sync2 #(.N(NUM_FLAGS)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  pfc_stable_filt #(.N(2), .FILT_CYCLES(FILT_CYCLES)) u_filt (
    .clk_i, .rst_ni, .d_i({syn[IDX_TRIG], syn[IDX_ARM]}), .q_o(zx_f)
  );

  assign gate_on  = (state_q == ST_ON);
  assign suppress = syn[IDX_UV] | syn[IDX_OVS] | syn[IDX_OVD];
  assign arm_rise = zx_f[0] & ~arm_fq;
  assign trig_evt = armed_q & zx_f[1] & ~trig_fq;
  assign turn_on  = ~gate_on & ~suppress & (trig_evt | wd_expire);

  pfc_watchdog #(.WD_CYCLES(WD_CYCLES)) u_wd (
    .clk_i, .rst_ni, .clear_i(turn_on | suppress), .expire_o(wd_expire)
  );

  pfc_on_timer #(
    .TON_W(TON_W), .TON_MIN(TON_MIN), .TON_MAX(TON_MAX), .BLANK_CYCLES(BLANK_CYCLES)
  ) u_ton (
    .clk_i, .rst_ni, .start_i(turn_on), .run_i(gate_on), .oc_i(syn[IDX_OC]),
    .ton_req_i, .done_o(tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_OFF;
      armed_q    <= 1'b0;
      arm_fq     <= 1'b0;
      trig_fq    <= 1'b0;
      wd_start_q <= 1'b0;
    end else begin
      arm_fq  <= zx_f[0];
      trig_fq <= zx_f[1];
      if (suppress)      state_q <= ST_OFF;
      else if (turn_on)  state_q <= ST_ON;
      else if (tmr_done) state_q <= ST_OFF;
      // a fresh arm is needed for every triggered cycle
      if (turn_on)       armed_q <= 1'b0;
      else if (arm_rise) armed_q <= 1'b1;
      if (turn_on)       wd_start_q <= ~trig_evt;
    end
  end

  assign gate_o     = gate_on;
  assign wd_start_o = wd_start_q;

  p_suppress_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suppress |=> !gate_o)
    else $error("gate on while suppressed");

  p_uvlo_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i && $past(uvlo_i) && $past(uvlo_i, 2) |=> !gate_o)
    else $error("gate on during lockout");

  p_src_armed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) && !wd_start_o |-> $past(armed_q))
    else $error("triggered turn-on without arm");
endmodule

// File: tb/pfc_seq_top_test.sv
module pfc_seq_top_test;
  localparam int TON_W = 12, TON_MIN = 8, TON_MAX = 100, BLANK = 6, WD = 300, FILT = 3;

  typedef struct {
    int    width;
    bit    wd;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic zx_arm = 1'b0, zx_trig = 1'b1, oc = 1'b0, ovs = 1'b0, ovd = 1'b0, uvlo = 1'b1;
  logic [TON_W-1:0] ton_req = 12'd20;
  logic gate_o, wd_start_o;
  int n_chk = 0, n_err = 0;
  exp_t exp_q[$];
  bit in_pulse = 1'b0;
  int pw = 0;
  bit psrc = 1'b0;

  always #4 clk = ~clk;

  pfc_seq_top #(.TON_W(TON_W), .TON_MIN(TON_MIN), .TON_MAX(TON_MAX), .BLANK_CYCLES(BLANK),
                .WD_CYCLES(WD), .FILT_CYCLES(FILT)) uut (
    .clk_i(clk), .rst_ni, .zx_arm_i(zx_arm), .zx_trig_i(zx_trig), .oc_i(oc),
    .ovp_static_i(ovs), .ovp_dyn_i(ovd), .uvlo_i(uvlo), .ton_req_i(ton_req),
    .gate_o, .wd_start_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int w, input bit wd, input string tag);
    exp_t e;
    e.width = w; e.wd = wd; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic zx_seq(input int ton);
    @(negedge clk);
    ton_req = TON_W'(ton);
    zx_trig = 1'b0;
    zx_arm  = 1'b1;
    cyc(8);
    zx_arm  = 1'b0;
    cyc(4);
    zx_trig = 1'b1;
  endtask

  task automatic zx_cycle(input int ton, input int w, input string tag);
    push(w, 1'b0, tag);
    zx_seq(ton);
    cyc(w + 20);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // monitor: measure each gate pulse and compare with the scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (gate_o) begin
        if (!in_pulse) begin
          in_pulse = 1'b1; pw = 1; psrc = wd_start_o;
        end else pw++;
      end else if (in_pulse) begin
        in_pulse = 1'b0;
        if (exp_q.size() == 0) chk(1'b0, "unexpected pulse R2/R7/R8/R9/R10", pw, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.width >= 0) chk(pw == e.width, {e.tag, " width"}, pw, e.width);
          chk(psrc == e.wd, {e.tag, " source"}, int'(psrc), int'(e.wd));
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog timeout", 0, 1);
    report();
  end

  initial begin
    int t1, t2, hi;
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    chk(gate_o == 1'b0 && wd_start_o == 1'b0, "R9 reset state", int'({gate_o, wd_start_o}), 0);
    // lockout: neither trigger nor watchdog may switch
    zx_seq(20);
    cyc(400);
    chk(gate_o == 1'b0, "R9 lockout hold", int'(gate_o), 0);
    uvlo = 1'b0;
    cyc(2);
    zx_cycle(20, 20, "R1 triggered pulse");
    zx_cycle(2, TON_MIN, "R5 min clamp");
    zx_cycle(500, TON_MAX, "R5 max clamp");
    // R10: one-cycle arm glitch is filtered out, trigger finds nothing armed
    zx_trig = 1'b0; zx_arm = 1'b1;
    cyc(1);
    zx_arm = 1'b0;
    cyc(6);
    zx_trig = 1'b1;
    cyc(30);
    chk(gate_o == 1'b0, "R10 arm glitch ignored", int'(gate_o), 0);
    // R2: trigger alone
    zx_trig = 1'b0;
    cyc(8);
    zx_trig = 1'b1;
    cyc(30);
    chk(gate_o == 1'b0, "R2 trigger without arm", int'(gate_o), 0);
    // R3: forced pulses at the watchdog interval
    ton_req = 12'd30;
    push(30, 1'b1, "R3 forced pulse 1");
    push(30, 1'b1, "R3 forced pulse 2");
    @(posedge gate_o); t1 = int'($time);
    @(posedge gate_o); t2 = int'($time);
    chk((t2 - t1) / 8 == WD, "R3 watchdog period", (t2 - t1) / 8, WD);
    @(negedge gate_o);
    cyc(2);
    zx_cycle(30, 30, "R4 resume triggered");
    // R6: over-current held from turn-on, pulse limited by blanking
    oc = 1'b1;
    zx_cycle(60, BLANK + 1, "R6 blanked trip");
    oc = 1'b0;
    cyc(2);
    zx_cycle(60, 60, "R6 normal after trip");
    // R7: static over-voltage blocks triggered and forced turn-on
    ovs = 1'b1;
    cyc(3);
    zx_seq(25);
    cyc(WD + 50);
    chk(gate_o == 1'b0, "R7 static ovp hold", int'(gate_o), 0);
    ovs = 1'b0;
    cyc(2);
    zx_cycle(25, 25, "R7 after static ovp");
    // R8: dynamic over-voltage truncates a running pulse
    push(-1, 1'b0, "R8 truncated pulse");
    zx_seq(80);
    @(posedge gate_o);
    cyc(10);
    ovd = 1'b1;
    hi = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (gate_o) hi++;
    end
    chk(hi <= 3 && gate_o == 1'b0, "R8 dyn ovp cut-off", hi, 3);
    cyc(WD + 50);
    chk(gate_o == 1'b0, "R8 dyn ovp hold", int'(gate_o), 0);
    ovd = 1'b0;
    cyc(2);
    zx_cycle(40, 40, "R8 after dyn ovp");
    uvlo = 1'b1;
    cyc(10);
    chk(exp_q.size() == 0, "R1 all expected pulses seen", exp_q.size(), 0);
    report();
  end
endmodule